// File: doc/BRIEF.md
# Auto-Increment Indirect Move Sequencer

This block carries out one auto-increment indirect move. Such a move reads an 8-bit pointer from a cell in SRAM and writes that pointer back plus one. It then either loads a data byte from the address the pointer named or stores the accumulator there. A single start pulse delivers every input the move needs: the direction, the pointer cell offset, the accumulator value and the paging inputs. The sequencer then drives a one-cycle synchronous SRAM port through exactly three transactions.

The pointer cell and the data byte can sit in different pages. The pointer cell follows the normal-access page rule: it uses the current page when the current-page enable is set, and page 0 when it is clear. The data byte always uses a dedicated page. For a load that is the load page input, and for a store it is the store page input. The current-page enable has no effect on the data page. When the move finishes, the block pulses done. On a load, the fetched byte is on the result output in that same cycle.

Top module: `mvi_sequencer`

## Requirements
- R1: A move accepted from idle issues exactly three SRAM transactions on consecutive cycles: a read of the pointer cell, a write to the same pointer cell, then the data access. The first transaction is in the cycle after start is sampled.
- R2: The SRAM address is {page, offset}, with the page in the upper PAGE_W bits and the 8-bit offset in the lower bits. The pointer cell address is {cur_page, ptr_cell} when cur_page_en is 1, and {0, ptr_cell} when it is 0.
- R3: The write-back value is the pointer read plus one, modulo 256. A pointer of 0xFF writes back 0x00, and the write-back stays in the same page.
- R4: On a load (is_load=1), the third transaction is a read at {load_page, old pointer}, where the old pointer is the value read before the increment. The byte it returns appears on result in the done cycle and is held afterwards.
- R5: On a store (is_load=0), the third transaction is a write of acc_in to {store_page, old pointer}. A store leaves result unchanged.
- R6: The data page comes from load_page or store_page whatever the value of cur_page_en.
- R7: busy is high from the cycle after start is sampled through the done cycle, four cycles in all. done is high for exactly one cycle, the fourth, and busy falls in the following cycle.
- R8: A start pulse while busy is high is ignored. It causes no extra transaction, and the values presented with it do not affect the move in progress.
- R9: After reset, busy, done and mem_en are 0 and result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a move (sampled only when idle) |
| is_load | input | 1 | 1 = load into accumulator, 0 = store accumulator |
| ptr_cell | input | 8 | Offset of the pointer cell |
| acc_in | input | 8 | Accumulator value for a store |
| cur_page_en | input | 1 | Enables the current page for the pointer cell |
| cur_page | input | PAGE_W | Current page |
| load_page | input | PAGE_W | Data page for loads |
| store_page | input | PAGE_W | Data page for stores |
| mem_en | output | 1 | SRAM transaction valid |
| mem_we | output | 1 | SRAM write (1) or read (0) |
| mem_addr | output | PAGE_W+8 | SRAM address {page, offset} |
| mem_wdata | output | 8 | SRAM write data |
| mem_rdata | input | 8 | SRAM read data, valid the cycle after a read |
| busy | output | 1 | Move in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 8 | Byte fetched by the last load |

## Verification
The bench aims at a pointer of 0xFF. A design that carried the increment into the page would write the pointer back to the wrong cell or leave it at 0x100 truncated into the wrong page. It also sets up a load whose data address equals the pointer cell, where the correct result is the already incremented pointer. A design that read from the increment or used the new pointer as the offset would return a different byte there. Moves are issued with cur_page_en cleared and a nonzero current page, to catch a pointer cell misplaced in the current page or a data page gated by the enable. Start is held high with garbage inputs during busy cycles, which exposes a sequencer that restarts or latches inputs mid-move.

// File: rtl/mvi_sequencer.sv
module mvi_sequencer #(
  parameter int PAGE_W = 3,
  parameter int DW     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 is_load,
  input  logic [DW-1:0]        ptr_cell,
  input  logic [DW-1:0]        acc_in,
  input  logic                 cur_page_en,
  input  logic [PAGE_W-1:0]    cur_page,
  input  logic [PAGE_W-1:0]    load_page,
  input  logic [PAGE_W-1:0]    store_page,
  output logic                 mem_en,
  output logic                 mem_we,
  output logic [PAGE_W+DW-1:0] mem_addr,
  output logic [DW-1:0]        mem_wdata,
  input  logic [DW-1:0]        mem_rdata,
  output logic                 busy,
  output logic                 done,
  output logic [DW-1:0]        result
);
  typedef enum logic [2:0] {S_IDLE, S_PRD, S_PWR, S_DATA, S_DONE} state_t;

  state_t             st;
  logic               load_q;
  logic [DW-1:0]      cell_q, acc_q, ptr_q, res_q;
  logic [PAGE_W-1:0]  ppage_q, dpage_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      load_q  <= 1'b0;
      cell_q  <= '0;
      acc_q   <= '0;
      ptr_q   <= '0;
      res_q   <= '0;
      ppage_q <= '0;
      dpage_q <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (start) begin
          load_q  <= is_load;
          cell_q  <= ptr_cell;
          acc_q   <= acc_in;
          ppage_q <= cur_page_en ? cur_page : '0;
          dpage_q <= is_load ? load_page : store_page;
          st      <= S_PRD;
        end
        S_PRD:  st <= S_PWR;
        S_PWR: begin
          ptr_q <= mem_rdata;
          st    <= S_DATA;
        end
        S_DATA: st <= S_DONE;
        S_DONE: begin
          if (load_q) res_q <= mem_rdata;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy      = (st != S_IDLE);
  assign done      = (st == S_DONE);
  assign mem_en    = (st == S_PRD) || (st == S_PWR) || (st == S_DATA);
  assign mem_we    = (st == S_PWR) || ((st == S_DATA) && !load_q);
  assign mem_addr  = (st == S_DATA) ? {dpage_q, ptr_q} : {ppage_q, cell_q};
  assign mem_wdata = (st == S_PWR)  ? mem_rdata + DW'(1) :
                     (st == S_DATA) ? acc_q : '0;
  assign result    = (done && load_q) ? mem_rdata : res_q;
endmodule

// File: rtl/mvi_sequencer_chk.sv
module mvi_sequencer_chk #(
  parameter int PAGE_W = 3,
  parameter int DW     = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic                 mem_en,
  input logic                 mem_we,
  input logic [PAGE_W+DW-1:0] mem_addr,
  input logic [DW-1:0]        mem_wdata,
  input logic [DW-1:0]        mem_rdata,
  input logic                 busy,
  input logic                 done
);
  a_r1_first_is_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> mem_en && !mem_we);

  a_r1_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> mem_en && mem_we);

  a_r3_writeback_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we && $past(mem_en && !mem_we)) |-> mem_wdata == mem_rdata + DW'(1));

  a_r3_same_cell: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we && $past(mem_en && !mem_we)) |-> mem_addr == $past(mem_addr));

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  a_r7_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy && !mem_en);

  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && start) |=> busy);
endmodule

bind mvi_sequencer mvi_sequencer_chk #(.PAGE_W(PAGE_W), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .mem_en(mem_en), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
  .busy(busy), .done(done)
);

// File: tb/mvi_sequencer_tb.sv
module mvi_sequencer_tb;
  localparam int PW = 3;
  localparam int AW = PW + 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, is_load = 1'b0, cur_page_en = 1'b0;
  logic [7:0] ptr_cell = '0, acc_in = '0;
  logic [PW-1:0] cur_page = '0, load_page = '0, store_page = '0;
  logic mem_en, mem_we, busy, done;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata, result;

  int checks = 0, errors = 0;
  logic [7:0] mem [0:(1<<AW)-1];
  logic [7:0] rdata_q = '0;
  int log_n = 0;
  logic          log_we [0:7];
  logic [AW-1:0] log_a  [0:7];
  logic [7:0]    log_d  [0:7];

  always #5 clk = ~clk;

  mvi_sequencer #(.PAGE_W(PW), .DW(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .is_load(is_load),
    .ptr_cell(ptr_cell), .acc_in(acc_in), .cur_page_en(cur_page_en),
    .cur_page(cur_page), .load_page(load_page), .store_page(store_page),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .result(result)
  );

  assign mem_rdata = rdata_q;

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else        rdata_q <= mem[mem_addr];
      if (log_n < 8) begin
        log_we[log_n] <= mem_we;
        log_a[log_n]  <= mem_addr;
        log_d[log_n]  <= mem_wdata;
      end
      log_n <= log_n + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] cell_addr(input logic en, input logic [PW-1:0] cp,
                                              input logic [7:0] off);
    return {en ? cp : PW'(0), off};
  endfunction

  task automatic run_op(input logic ld, input logic [7:0] pc, input logic [7:0] acc,
                        input logic en, input logic [PW-1:0] cp,
                        input logic [PW-1:0] lp, input logic [PW-1:0] sp,
                        input bit noisy);
    logic [AW-1:0] pa, da;
    logic [7:0] oldp, exp_res, prev_res;
    pa = cell_addr(en, cp, pc);
    oldp = mem[pa];
    da = {ld ? lp : sp, oldp};
    exp_res = (da == pa) ? oldp + 8'd1 : mem[da];
    prev_res = result;
    @(negedge clk);
    log_n = 0;
    start = 1'b1; is_load = ld; ptr_cell = pc; acc_in = acc;
    cur_page_en = en; cur_page = cp; load_page = lp; store_page = sp;
    for (int c = 1; c <= 4; c++) begin
      @(negedge clk);
      if (noisy && c < 4) begin
        start = 1'b1; is_load = $urandom; ptr_cell = $urandom; acc_in = $urandom;
        cur_page_en = $urandom; cur_page = $urandom; load_page = $urandom; store_page = $urandom;
      end else start = 1'b0;
      chk(busy == 1'b1, "R7 busy", busy, 1);
      chk(done == (c == 4), "R7 done timing", done, c == 4);
    end
    if (ld) chk(result == exp_res, "R4 load result in done cycle", result, exp_res);
    @(negedge clk);
    start = 1'b0;
    chk(!busy && !done, "R7 idle after done", {busy, done}, 0);
    chk(log_n == 3, "R1 R8 transaction count", log_n, 3);
    chk(log_we[0] == 0 && log_a[0] == pa, "R1 R2 pointer read", log_a[0], pa);
    chk(log_we[1] == 1 && log_a[1] == pa, "R1 R3 writeback cell", log_a[1], pa);
    chk(log_d[1] == oldp + 8'd1, "R3 writeback value", log_d[1], oldp + 8'd1);
    chk(log_a[2] == da, "R4 R5 R6 data address", log_a[2], da);
    chk(log_we[2] == !ld, "R4 R5 data direction", log_we[2], !ld);
    if (!ld) begin
      chk(log_d[2] == acc, "R5 store data", log_d[2], acc);
      chk(result == prev_res, "R5 result unchanged", result, prev_res);
    end else
      chk(result == exp_res, "R4 result held", result, exp_res);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < (1<<AW); i++) mem[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_en && result == 0, "R9 reset state",
        {busy, done, mem_en, result}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !mem_en, "R9 idle after reset", {busy, mem_en}, 0);

    mem[{3'd5, 8'h10}] = 8'hFF;
    run_op(1'b1, 8'h10, 8'h00, 1'b1, 3'd5, 3'd2, 3'd6, 1'b0);   // R3 wrap on load
    chk(mem[{3'd5, 8'h10}] == 8'h00, "R3 wrap stored", mem[{3'd5, 8'h10}], 0);
    mem[{3'd0, 8'h20}] = 8'hFF;
    run_op(1'b0, 8'h20, 8'hA5, 1'b0, 3'd7, 3'd1, 3'd3, 1'b0);   // R2 R6 page 0 rule
    chk(mem[{3'd3, 8'hFF}] == 8'hA5, "R5 store landed", mem[{3'd3, 8'hFF}], 8'hA5);
    mem[{3'd4, 8'h33}] = 8'h33;
    run_op(1'b1, 8'h33, 8'h00, 1'b1, 3'd4, 3'd4, 3'd0, 1'b0);   // R4 data hits pointer cell
    run_op(1'b1, 8'h40, 8'h11, 1'b0, 3'd6, 3'd5, 3'd1, 1'b1);   // R8 start held while busy
    run_op(1'b0, 8'h41, 8'h22, 1'b1, 3'd2, 3'd0, 3'd7, 1'b1);   // R8 on store

    for (int n = 0; n < 300; n++)
      run_op($urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom,
             ($urandom % 3) == 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule